// File: doc/BRIEF.md
# Receive FIFO Controller with Character Timeout

This block is the receive-side queue and its control register for a 16550-class serial port. A host write port loads one control byte. That byte switches queued mode on or off, can empty the receive queue, can request a flush of the transmit queue (which is kept elsewhere), picks how full the queue must be before received data is announced, and records a DMA signalling mode. The receive shifter delivers bytes on a valid/ready input stream. The receive buffer read pops bytes through a valid/ready output stream.

When queued mode is off, the queue behaves as a single-byte holding register. When it is on, the queue holds up to DEPTH bytes (16 by default). A character-time tick from the baud logic drives an idle detector. If bytes are waiting and nothing moves in or out for four character times, the detector raises a timeout.

The input stream has no back-pressure in the usual sense, because the shifter cannot stall. `in_ready` only tells the source whether space is left. A beat offered while `in_ready` is low is discarded and reported as an overrun. On the output side, a pop happens on any cycle where `out_valid` and `out_ready` are both high. `out_data` is valid whenever `out_valid` is high.

Top module: `rx_fifo_ctl`

## Requirements
- R1: After reset the queue is empty (`out_valid`=0, `in_ready`=1), queued mode is off, `data_avail`, `char_timeout`, `dma_mode`, `tx_flush` and `overrun` are 0.
- R2: Control byte layout: bit0 enable, bit1 receive clear, bit2 transmit clear, bit3 DMA mode, bits 7:6 trigger select. The trigger and DMA fields load only from a write whose bit0 is 1. A write with bit0 = 0 leaves `dma_mode` unchanged.
- R3: A write whose bit0 differs from the current mode empties the receive queue at that clock edge. It also raises `tx_flush` for one cycle in the following cycle.
- R4: A write with bit0 = 1 and bit1 = 1 empties the receive queue. A write with bit0 = 1 and bit2 = 1 pulses `tx_flush` for one cycle. Both clear bits act once and are not retained, so a later write without them leaves the queue intact.
- R5: Trigger select 00, 01, 10 and 11 gives levels of 1, 4, 8 and 14 bytes. In queued mode, `data_avail` is high while occupancy is at or above the selected level.
- R6: In queued mode the queue holds DEPTH bytes and returns them in arrival order.
- R7: `in_ready` is low exactly when the queue is full. A beat offered then is dropped, the stored bytes are unchanged, and `overrun` is high for one cycle in the following cycle.
- R8: With queued mode off, capacity is one byte, `data_avail` is high whenever a byte is held, and `char_timeout` never asserts.
- R9: In queued mode with at least one byte stored, `char_timeout` rises on the fourth `char_tick` with no push or pop in between. Any push or pop restarts the count.
- R10: `char_timeout` stays high until the next pop, and is low in the cycle after that pop.
- R11: `fifo_enabled` follows bit0 of the most recent control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control byte |
| in_valid | input | 1 | Byte offered by the receive shifter |
| in_ready | output | 1 | Space available in the queue |
| in_data | input | DW | Received byte |
| out_valid | output | 1 | Queue not empty |
| out_ready | input | 1 | Receive buffer read (pop) |
| out_data | output | DW | Oldest stored byte |
| char_tick | input | 1 | One-cycle pulse per character time |
| data_avail | output | 1 | Occupancy at or above trigger level |
| char_timeout | output | 1 | Idle timeout with data waiting |
| fifo_enabled | output | 1 | Queued mode active |
| dma_mode | output | 1 | Stored DMA signalling mode |
| tx_flush | output | 1 | One-cycle transmit queue clear request |
| overrun | output | 1 | One-cycle pulse on a dropped byte |

## Verification
Several rules are checked on every cycle by the assertions:
- a refused beat produces an overrun;
- a mode toggle empties the queue and requests a transmit flush;
- a write with the enable bit low leaves the DMA mode alone;
- no timeout appears outside queued mode;
- a pop clears the timeout;
- `data_avail` never asserts on an empty queue;
- capacity is one byte in single-byte mode.

Only the bench scenarios can show the rest:
- byte ordering across a full queue;
- the exact occupancy at which each trigger level trips;
- that the fourth idle tick, and not the third, raises the timeout;
- that push activity restarts the idle count;
- that the clear bits do not persist.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_e;

  // Control byte layout, MSB first
  typedef struct packed {
    logic [1:0] trig;
    logic [1:0] rsvd;
    logic       dma;
    logic       tx_clr;
    logic       rx_clr;
    logic       en;
  } cfg_t;

  function automatic int trig_level(trig_e t);
    case (t)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output logic        fifo_en,
  output logic        dma,
  output trig_e       trig,
  output logic        rx_flush,
  output logic        tx_flush
);

  cfg_t w;
  assign w = cfg_t'(wdata);

  logic unused_rsvd;
  assign unused_rsvd = ^w.rsvd;

  logic toggle, unlocked, tx_flush_d;

  // Fields other than the enable only load with enable set in the same write
  assign unlocked   = wr && w.en;
  assign toggle     = wr && (w.en != fifo_en);
  assign rx_flush   = toggle || (unlocked && w.rx_clr);
  assign tx_flush_d = toggle || (unlocked && w.tx_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      dma      <= 1'b0;
      trig     <= TRIG_1;
      tx_flush <= 1'b0;
    end else begin
      tx_flush <= tx_flush_d;
      if (wr) fifo_en <= w.en;
      if (unlocked) begin
        trig <= trig_e'(w.trig);
        dma  <= w.dma;
      end
    end
  end

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fifo_en,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop_ready,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          push_fire,
  output logic          pop_fire,
  output logic          overrun
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cap;
  logic          full;

  // Single-byte holding register when queued mode is off
  assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full       = (count >= cap);
  assign push_ready = !full;
  assign pop_valid  = (count != '0);
  assign push_fire  = push_valid && !full && !flush;
  assign pop_fire   = pop_ready && pop_valid && !flush;
  assign pop_data   = mem[rp];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_fire && (wp == PW'(i))) mem[i] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= push_valid && full && !flush;
      if (flush) begin
        wp    <= '0;
        rp    <= '0;
        count <= '0;
      end else begin
        if (push_fire) wp <= nxt(wp);
        if (pop_fire)  rp <= nxt(rp);
        case ({push_fire, pop_fire})
          2'b10:   count <= count + CW'(1);
          2'b01:   count <= count - CW'(1);
          default: count <= count;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxf_idle.sv
module rxf_idle #(
  parameter int CHARS = 4,
  localparam int NW   = $clog2(CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic activity,
  input  logic pop_fire,
  input  logic flush,
  input  logic tick,
  output logic timeout
);

  logic [NW-1:0] cnt;
  logic          last;

  assign last = (cnt == NW'(CHARS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      if (!arm || activity || flush)
        cnt <= '0;
      else if (tick && !last)
        cnt <= cnt + NW'(1);

      if (flush || pop_fire)
        timeout <= 1'b0;
      else if (arm && tick && !activity && last)
        timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl
  import rxf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_CHARS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          char_tick,
  output logic          data_avail,
  output logic          char_timeout,
  output logic          fifo_enabled,
  output logic          dma_mode,
  output logic          tx_flush,
  output logic          overrun
);

  localparam int CW = $clog2(DEPTH + 1);

  trig_e         trig;
  logic          rx_flush, push_fire, pop_fire;
  logic [CW-1:0] count;
  int            level;

  rxf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .fifo_en  (fifo_enabled),
    .dma      (dma_mode),
    .trig     (trig),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (rx_flush),
    .fifo_en    (fifo_enabled),
    .push_valid (in_valid),
    .push_data  (in_data),
    .push_ready (in_ready),
    .pop_ready  (out_ready),
    .pop_valid  (out_valid),
    .pop_data   (out_data),
    .count      (count),
    .push_fire  (push_fire),
    .pop_fire   (pop_fire),
    .overrun    (overrun)
  );

  rxf_idle #(.CHARS(TO_CHARS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (fifo_enabled && out_valid),
    .activity (push_fire || pop_fire),
    .pop_fire (pop_fire),
    .flush    (rx_flush),
    .tick     (char_tick),
    .timeout  (char_timeout)
  );

  assign level      = fifo_enabled ? trig_level(trig) : 1;
  assign data_avail = (int'(count) >= level);

endmodule

// File: rtl/rx_fifo_ctl_chk.sv
module rx_fifo_ctl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [7:0]    cfg_wdata,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          data_avail,
  input logic          char_timeout,
  input logic          fifo_enabled,
  input logic          dma_mode,
  input logic          tx_flush,
  input logic          overrun
);

  p_lock_dma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_wdata[0] |=> $stable(dma_mode));

  p_toggle_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_wdata[0] != fifo_enabled) |=> !out_valid && tx_flush);

  p_avail_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> out_valid);

  p_refused_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && !cfg_wr |=> overrun);

  p_full_not_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  p_single_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_enabled && out_valid |-> !in_ready);

  p_no_timeout_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_enabled |-> !char_timeout);

  p_pop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !char_timeout);

  p_mode_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> fifo_enabled == $past(cfg_wdata[0]));

endmodule

bind rx_fifo_ctl rx_fifo_ctl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_wdata    (cfg_wdata),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .data_avail   (data_avail),
  .char_timeout (char_timeout),
  .fifo_enabled (fifo_enabled),
  .dma_mode     (dma_mode),
  .tx_flush     (tx_flush),
  .overrun      (overrun)
);

// File: tb/rx_fifo_ctl_test.sv
`timescale 1ns/100ps
module rx_fifo_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       char_tick = 1'b0;
  logic       data_avail, char_timeout, fifo_enabled, dma_mode, tx_flush, overrun;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] sb[$];

  always #2.5 clk = ~clk;

  rx_fifo_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .char_tick(char_tick), .data_avail(data_avail), .char_timeout(char_timeout),
    .fifo_enabled(fifo_enabled), .dma_mode(dma_mode), .tx_flush(tx_flush),
    .overrun(overrun)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    step();
    cfg_wr = 1'b0;
  endtask

  // Driver: predicts acceptance from in_ready and queues the expected byte
  task automatic push(logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    if (in_ready) sb.push_back(b);
    step();
    in_valid = 1'b0;
  endtask

  task automatic pop();
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    step();
    char_tick = 1'b0;
    step();
  endtask

  // Monitor: compares each popped byte against the scoreboard (R6 ordering)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) chk("R6 unexpected pop", 1, 0);
      else chk("R6 pop data", int'(out_data), int'(sb.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 fifo_enabled", fifo_enabled, 0);
    chk("R1 data_avail", data_avail, 0);
    chk("R1 char_timeout", char_timeout, 0);
    chk("R1 dma_mode", dma_mode, 0);

    // R8 single-byte mode
    push(8'hA1);
    chk("R8 held byte avail", data_avail, 1);
    chk("R8 full at one", in_ready, 0);
    push(8'hA2);
    chk("R7 overrun pulse", overrun, 1);
    step();
    chk("R7 overrun one cycle", overrun, 0);
    for (int i = 0; i < 6; i++) tick();
    chk("R8 no timeout", char_timeout, 0);
    pop();
    chk("R8 empty after pop", out_valid, 0);

    // R3/R11 enable: trig 14, DMA on
    wr(8'hC9);
    chk("R11 enabled", fifo_enabled, 1);
    chk("R3 tx_flush on toggle", tx_flush, 1);
    chk("R2 dma loaded", dma_mode, 1);
    step();
    chk("R3 tx_flush one cycle", tx_flush, 0);

    // R5 trigger 4
    wr(8'h49);
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
    chk("R5 below 4", data_avail, 0);
    push(8'h13);
    chk("R5 at 4", data_avail, 1);
    wr(8'h89);
    chk("R5 trig 8 with 4", data_avail, 0);
    for (int i = 0; i < 4; i++) push(8'h14 + 8'(i));
    chk("R5 at 8", data_avail, 1);
    wr(8'hC9);
    for (int i = 0; i < 5; i++) push(8'h18 + 8'(i));
    chk("R5 at 13 of 14", data_avail, 0);
    push(8'h1D);
    chk("R5 at 14", data_avail, 1);
    push(8'h1E); push(8'h1F);
    chk("R7 full 16", in_ready, 0);
    push(8'hEE);
    chk("R7 overrun queued", overrun, 1);
    for (int i = 0; i < 16; i++) pop();
    chk("R6 drained", out_valid, 0);
    chk("R6 scoreboard empty", sb.size(), 0);

    // R4 receive clear and no persistence
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i));
    wr(8'hCB);
    sb.delete();
    chk("R4 rx clear", out_valid, 0);
    chk("R4 rx clear no tx", tx_flush, 0);
    push(8'h40); push(8'h41);
    wr(8'hC9);
    chk("R4 no repeat clear", out_valid, 1);
    wr(8'hCD);
    chk("R4 tx clear pulse", tx_flush, 1);
    chk("R4 tx clear keeps rx", out_valid, 1);
    step();
    chk("R4 tx clear once", tx_flush, 0);
    pop(); pop();

    // R9/R10 timeout
    push(8'h50);
    for (int i = 0; i < 3; i++) tick();
    chk("R9 not after 3", char_timeout, 0);
    tick();
    chk("R9 after 4", char_timeout, 1);
    push(8'h51);
    chk("R10 push keeps timeout", char_timeout, 1);
    pop();
    chk("R10 cleared by pop", char_timeout, 0);
    for (int i = 0; i < 3; i++) tick();
    push(8'h52);
    for (int i = 0; i < 3; i++) tick();
    chk("R9 restart on push", char_timeout, 0);
    tick();
    chk("R9 after restart", char_timeout, 1);

    // R3 toggle off flushes; R2 lock while disabled
    wr(8'h00);
    sb.delete();
    chk("R3 flush on disable", out_valid, 0);
    chk("R3 tx_flush on disable", tx_flush, 1);
    chk("R11 disabled", fifo_enabled, 0);
    chk("R2 dma kept on disable", dma_mode, 1);
    chk("R8 timeout cleared", char_timeout, 0);
    wr(8'h00);
    chk("R2 dma locked", dma_mode, 1);
    wr(8'h01);
    chk("R2 dma reload", dma_mode, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule